// File: doc/BRIEF.md
# Processor Wake-up Interrupt Sequencer

This block wakes a sleeping processor by driving an interrupt command register that has a low word and a high word. After one start pulse it sends three messages: a reset-style INIT message, then two identical start-up messages. A fixed pause of 10 µs comes after the INIT message and a fixed pause of 200 µs comes after the first start-up message. Each message is a write of the high word (the destination) followed by a write of the low word, and the low-word write is what sends it. After every send the block keeps reading the low word until the delivery-pending bit clears. Only then does it move on.

The start-up message carries an 8-bit vector equal to the 4 KB page number of the start-up routine, so the routine address must lie below 1 MB and on a page boundary. A bad address is rejected at once. The pauses are counted in clock cycles derived from a clock-rate parameter. A parameterised limit stops a delivery poll that never clears.

Top module: `ipi_boot_seq`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `done_o`, `err_o`, `wr_hi_o`, `wr_lo_o` and `rd_lo_o` are all low.
- R2: A start while idle is rejected when the routine address has any bit above bit 19 set or any of bits 11:0 set. On the next cycle `done_o` and `err_o` are high, `busy_o` never rises, and no command-register write is made.
- R3: An accepted start produces exactly three messages, in order: INIT, start-up, start-up. Each message is a high-word write followed on the very next cycle by its low-word write, and at most one of the strobes is high in any cycle.
- R4: The high word carries the target ID in bits 31:24 and zero in bits 23:0. In broadcast mode the high word is all zero.
- R5: Every low word has bit 14 (level) set to 1. Bits 10:8 hold the delivery mode: 3'b101 for INIT, 3'b110 for start-up. Bits 19:18 are 2'b11 in broadcast mode and 2'b00 otherwise. All other bits outside 7:0 are 0.
- R6: The start-up vector (low-word bits 7:0) equals routine address bits 19:12. The INIT vector is 0.
- R7: From the cycle after each low-word write, `rd_lo_o` is high on every cycle until a cycle in which `dlv_pend_i` reads 0. No register write is made while the pending bit reads 1.
- R8: The next high-word write comes exactly INIT_GAP_US*CYC_PER_US+1 cycles after the clearing read of the INIT message. For the first start-up message the gap is exactly START_GAP_US*CYC_PER_US+1 cycles.
- R9: If POLL_LIMIT consecutive reads of one message all see the pending bit set, the sequence is aborted. `done_o` and `err_o` rise on the next cycle, and no further writes or reads follow.
- R10: `busy_o` is high from the cycle after an accepted start until the clearing read of the last message. `done_o` is a one-cycle pulse at the end, with `busy_o` low. `err_o` is 0 after a successful sequence.
- R11: A start pulse while `busy_o` is high is ignored. The running sequence keeps its target, mode and vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| target_id_i | input | ID_W | Destination processor ID |
| bcast_i | input | 1 | Send to all processors except self |
| rtn_addr_i | input | ADDR_W | Physical address of the start-up routine |
| dlv_pend_i | input | 1 | Delivery-pending bit from the low command word |
| wr_hi_o | output | 1 | High command word write strobe |
| wr_lo_o | output | 1 | Low command word write strobe (sends the message) |
| rd_lo_o | output | 1 | Low command word read strobe (status poll) |
| wr_data_o | output | 32 | Write data for either command word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Last sequence was rejected or timed out |

## Verification
- **Start to first write:** a start reaches the registers one cycle later, so the first high-word write, or the reject pulse for a bad address, is sampled on the next falling edge. The low-word write always follows one cycle after its high-word write.
- **Poll timing:** the first poll comes one cycle after the low-word write. The acceptance model in the bench holds the pending bit for a chosen number of cycles, so the clearing read must land exactly that many cycles plus one after the write.
- **Pause timing:** the gaps are checked as cycle differences from the clearing read to the next high-word write, against pause × CYC_PER_US + 1.
- **End of sequence:** `done_o` is sampled on the falling edge after the final clearing read.
- **Sampling:** all sampling happens on the falling edge, half a period away from the edge that moves the state.

// File: rtl/ipi_boot_pkg.sv
package ipi_boot_pkg;
  localparam int unsigned CMD_W    = 32;
  localparam int unsigned VEC_LSB  = 0;
  localparam int unsigned DM_LSB   = 8;
  localparam int unsigned LVL_BIT  = 14;
  localparam int unsigned SH_LSB   = 18;
  localparam int unsigned ID_LSB   = 24;
  localparam int unsigned PAGE_LSB = 12;
  localparam int unsigned LIM_LSB  = 20;

  typedef enum logic [2:0] {
    DM_INIT  = 3'b101,
    DM_START = 3'b110
  } dmode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WR_HI, S_WR_LO, S_POLL, S_WAIT
  } seq_st_e;

  function automatic logic [CMD_W-1:0] build_lo(dmode_e dm, logic [7:0] vec, logic bc);
    logic [CMD_W-1:0] w;
    w = '0;
    w[VEC_LSB +: 8] = vec;
    w[DM_LSB +: 3]  = dm;
    w[LVL_BIT]      = 1'b1;
    w[SH_LSB +: 2]  = {2{bc}};
    return w;
  endfunction
endpackage

// File: rtl/ipi_wait_timer.sv
module ipi_wait_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ipi_poll_guard.sv
module ipi_poll_guard #(
  parameter int unsigned POLL_LIMIT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic poll_i,
  input  logic pend_i,
  output logic clear_o,
  output logic tmo_o
);
  localparam int unsigned PW = $clog2(POLL_LIMIT + 1);
  localparam logic [PW-1:0] LAST = PW'(POLL_LIMIT - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (arm_i)            cnt_q <= '0;
    else if (poll_i && pend_i) cnt_q <= cnt_q + 1'b1;
  end

  assign clear_o = poll_i && !pend_i;
  assign tmo_o   = poll_i && pend_i && (cnt_q == LAST);
endmodule

// File: rtl/ipi_boot_seq.sv
module ipi_boot_seq
  import ipi_boot_pkg::*;
#(
  parameter int unsigned CYC_PER_US   = 100,
  parameter int unsigned INIT_GAP_US  = 10,
  parameter int unsigned START_GAP_US = 200,
  parameter int unsigned POLL_LIMIT   = 1024,
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned ID_W         = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ID_W-1:0]   target_id_i,
  input  logic              bcast_i,
  input  logic [ADDR_W-1:0] rtn_addr_i,
  input  logic              dlv_pend_i,
  output logic              wr_hi_o,
  output logic              wr_lo_o,
  output logic              rd_lo_o,
  output logic [CMD_W-1:0]  wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned INIT_CYC  = INIT_GAP_US * CYC_PER_US;
  localparam int unsigned START_CYC = START_GAP_US * CYC_PER_US;
  localparam int unsigned MAX_CYC   = (INIT_CYC > START_CYC) ? INIT_CYC : START_CYC;
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);
  localparam logic [1:0]  LAST_MSG  = 2'd2;

  seq_st_e         st_q;
  logic [1:0]      msg_q;
  logic [ID_W-1:0] id_q;
  logic            bc_q;
  logic [7:0]      vec_q;
  logic            done_q, err_q;
  logic            addr_ok, poll_clr, poll_tmo, tmr_zero, tmr_load;
  logic [CNT_W-1:0] tmr_val;

  assign addr_ok = (rtn_addr_i[PAGE_LSB-1:0] == '0) &&
                   (rtn_addr_i[ADDR_W-1:LIM_LSB] == '0);

  ipi_poll_guard #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (st_q == S_WR_LO),
    .poll_i  (st_q == S_POLL),
    .pend_i  (dlv_pend_i),
    .clear_o (poll_clr),
    .tmo_o   (poll_tmo)
  );

  // Gap counter loads on the clearing read, so WAIT lasts exactly N cycles
  assign tmr_load = poll_clr && (msg_q != LAST_MSG);
  assign tmr_val  = (msg_q == 2'd0) ? CNT_W'(INIT_CYC - 1) : CNT_W'(START_CYC - 1);

  ipi_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      msg_q  <= '0;
      id_q   <= '0;
      bc_q   <= 1'b0;
      vec_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          if (addr_ok) begin
            st_q  <= S_WR_HI;
            msg_q <= '0;
            id_q  <= bcast_i ? '0 : target_id_i;
            bc_q  <= bcast_i;
            vec_q <= rtn_addr_i[PAGE_LSB +: 8];
            err_q <= 1'b0;
          end else begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
          end
        end
        S_WR_HI: st_q <= S_WR_LO;
        S_WR_LO: st_q <= S_POLL;
        S_POLL: begin
          if (poll_tmo) begin
            st_q   <= S_IDLE;
            err_q  <= 1'b1;
            done_q <= 1'b1;
          end else if (poll_clr) begin
            if (msg_q == LAST_MSG) begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              st_q <= S_WAIT;
            end
          end
        end
        S_WAIT: if (tmr_zero) begin
          st_q  <= S_WR_HI;
          msg_q <= msg_q + 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_data_o = '0;
    if (st_q == S_WR_HI)
      wr_data_o = CMD_W'(id_q) << ID_LSB;
    else if (st_q == S_WR_LO)
      wr_data_o = (msg_q == 2'd0) ? build_lo(DM_INIT, 8'h00, bc_q)
                                  : build_lo(DM_START, vec_q, bc_q);
  end

  assign wr_hi_o = (st_q == S_WR_HI);
  assign wr_lo_o = (st_q == S_WR_LO);
  assign rd_lo_o = (st_q == S_POLL);
  assign busy_o  = (st_q != S_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/ipi_boot_seq_chk.sv
module ipi_boot_seq_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] rtn_addr_i,
  input logic              dlv_pend_i,
  input logic              wr_hi_o,
  input logic              wr_lo_o,
  input logic              rd_lo_o,
  input logic [31:0]       wr_data_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o
);
  logic bad_addr;
  assign bad_addr = (rtn_addr_i[11:0] != '0) || (rtn_addr_i[ADDR_W-1:20] != '0);

  AST_REJECT_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && bad_addr |=> done_o && err_o && !busy_o); // R2
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_hi_o, wr_lo_o, rd_lo_o})); // R3
  AST_HI_THEN_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_o |=> wr_lo_o); // R3
  AST_LO_AFTER_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_o |-> $past(wr_hi_o)); // R3
  AST_HI_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_o |-> wr_data_o[23:0] == '0); // R4
  AST_LO_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_o |-> wr_data_o[31:20] == '0 && wr_data_o[17:15] == '0 && wr_data_o[14]
                && wr_data_o[13:11] == '0
                && (wr_data_o[10:8] == 3'b101 || wr_data_o[10:8] == 3'b110)); // R5
  AST_LO_SHORTHAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_o |-> wr_data_o[19] == wr_data_o[18]); // R5
  AST_INIT_VEC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_o && wr_data_o[10:8] == 3'b101 |-> wr_data_o[7:0] == '0); // R6
  AST_POLL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_o |=> rd_lo_o); // R7
  AST_NO_WR_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_o && dlv_pend_i |=> !wr_hi_o && !wr_lo_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R10
  AST_STROBE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_o || wr_lo_o || rd_lo_o) |-> busy_o); // R10
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !bad_addr |=> busy_o && wr_hi_o); // R10
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !busy_o && !done_o && !err_o); // R1
endmodule

bind ipi_boot_seq ipi_boot_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .rtn_addr_i (rtn_addr_i),
  .dlv_pend_i (dlv_pend_i),
  .wr_hi_o    (wr_hi_o),
  .wr_lo_o    (wr_lo_o),
  .rd_lo_o    (rd_lo_o),
  .wr_data_o  (wr_data_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/ipi_boot_seq_tb_top.sv
module ipi_boot_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CPU = 2;
  localparam int IUS = 10;
  localparam int SUS = 200;
  localparam int PL  = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start = 1'b0, bcast = 1'b0, pend;
  logic [7:0] tid = '0;
  logic [31:0] addr = '0;
  logic wr_hi, wr_lo, rd_lo, busy, done, err;
  logic [31:0] wdata;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int stall = 0, pend_cnt = 0;
  int n_hi, n_lo, n_clr, n_rd;
  int busy_seen;
  logic [31:0] hi_d[4], lo_d[4];
  int hi_c[4], lo_c[4], clr_c[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_boot_seq #(.CYC_PER_US(CPU), .INIT_GAP_US(IUS), .START_GAP_US(SUS),
                 .POLL_LIMIT(PL), .ADDR_W(32), .ID_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .target_id_i(tid),
    .bcast_i(bcast), .rtn_addr_i(addr), .dlv_pend_i(pend),
    .wr_hi_o(wr_hi), .wr_lo_o(wr_lo), .rd_lo_o(rd_lo), .wr_data_o(wdata),
    .busy_o(busy), .done_o(done), .err_o(err));

  // Acceptance model: pending bit held for `stall` cycles after each send
  always @(posedge clk) begin
    if (wr_lo) pend_cnt <= stall;
    else if (pend_cnt != 0) pend_cnt <= pend_cnt - 1;
  end
  assign pend = (pend_cnt != 0);

  always @(negedge clk) begin
    cyc++;
    if (busy) busy_seen = 1;
    if (wr_hi && n_hi < 4) begin hi_d[n_hi] = wdata; hi_c[n_hi] = cyc; n_hi++; end
    if (wr_lo && n_lo < 4) begin lo_d[n_lo] = wdata; lo_c[n_lo] = cyc; n_lo++; end
    if (rd_lo) n_rd++;
    if (rd_lo && !pend && n_clr < 4) begin clr_c[n_clr] = cyc; n_clr++; end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    n_hi = 0; n_lo = 0; n_clr = 0; n_rd = 0; busy_seen = 0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 3000 && !done; k++) @(negedge clk);
  endtask

  task automatic run_good(input logic [7:0] page, input logic [7:0] id, input bit bc,
                          input int stl, input bit intrude);
    logic [31:0] exp_hi, sh;
    stall = stl;
    clear_log();
    tid = id; bcast = bc; addr = {12'h0, page, 12'h0}; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      repeat (30) @(negedge clk);
      tid = ~id; bcast = ~bc; addr = 32'h0000_2000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done();
    chk(done && !err, "R10 done without error", {err, done}, 32'h1);
    chk(n_hi == 3 && n_lo == 3, "R3 message count", n_hi * 16 + n_lo, 32'h33);
    exp_hi = bc ? 32'h0 : {id, 24'h0};
    sh = bc ? 32'h000C_0000 : 32'h0;
    for (int i = 0; i < 3; i++) begin
      chk(hi_d[i] == exp_hi, intrude ? "R11 high word kept" : "R4 high word", hi_d[i], exp_hi);
      chk(lo_c[i] == hi_c[i] + 1, "R3 low follows high", lo_c[i] - hi_c[i], 32'h1);
      chk(clr_c[i] == lo_c[i] + stl + 1, "R7 clearing read cycle", clr_c[i] - lo_c[i], stl + 1);
    end
    chk(lo_d[0] == (32'h0000_4500 | sh), "R5 INIT low word", lo_d[0], 32'h4500 | sh);
    chk(lo_d[1] == (32'h0000_4600 | sh | page), "R6 start-up low word", lo_d[1], 32'h4600 | sh | page);
    chk(lo_d[2] == lo_d[1], "R6 second start-up identical", lo_d[2], lo_d[1]);
    chk(hi_c[1] - clr_c[0] == IUS * CPU + 1, "R8 INIT gap", hi_c[1] - clr_c[0], IUS * CPU + 1);
    chk(hi_c[2] - clr_c[1] == SUS * CPU + 1, "R8 start-up gap", hi_c[2] - clr_c[1], SUS * CPU + 1);
    chk(n_rd == 3 * (stl + 1), "R7 poll count", n_rd, 3 * (stl + 1));
    @(negedge clk);
    chk(!done && !busy, "R10 done single pulse", {busy, done}, 32'h0);
  endtask

  task automatic run_bad(input logic [31:0] a);
    clear_log();
    stall = 0; tid = 8'h11; bcast = 1'b0; addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && err, "R2 reject pulse", {done, err}, 32'h3);
    repeat (3) @(negedge clk);
    chk(n_hi == 0 && n_lo == 0 && busy_seen == 0, "R2 no writes no busy", n_hi + n_lo + busy_seen, 32'h0);
    chk(!done && err, "R2 error held, pulse ended", {done, err}, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] pages[4];
    int stalls[3];
    pages[0] = 8'h00; pages[1] = 8'h01; pages[2] = 8'h9F; pages[3] = 8'hFF;
    stalls[0] = 0; stalls[1] = 3; stalls[2] = PL - 1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !wr_hi && !wr_lo && !rd_lo, "R1 reset quiet",
        {busy, done, err, wr_hi, wr_lo, rd_lo}, 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !err, "R1 after release", {busy, done, err}, 32'h0);

    for (int p = 0; p < 4; p++)
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < 3; s++)
          run_good(pages[p], pages[p] ^ 8'hA5, b[0], stalls[s], 1'b0);

    run_bad(32'h0010_0000);
    run_bad(32'h0000_1001);
    run_bad(32'hFFFF_F000);
    run_bad(32'h0000_0800);
    run_bad(32'h0009_F004);

    run_good(8'h42, 8'h5A, 1'b0, 2, 1'b1);

    // R9: pending never clears within the limit
    clear_log();
    stall = PL; tid = 8'h77; bcast = 1'b0; addr = 32'h0003_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(done && err, "R9 timeout abort", {done, err}, 32'h3);
    chk(n_rd == PL && n_clr == 0, "R9 poll reads before abort", n_rd, PL);
    repeat (PL + 4) @(negedge clk);
    chk(n_hi == 1 && n_lo == 1 && !busy, "R9 nothing after abort", n_hi * 16 + n_lo, 32'h11);

    run_good(8'h10, 8'h3C, 1'b0, 1, 1'b0);
    chk(!err, "R10 error cleared by good run", err, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule